// File: doc/BRIEF.md
# CRT Overflow Coefficient Estimator

In a residue-number reconstruction, the integer to be rebuilt is a sum of weighted channel residues, and the sum must be reduced by some whole number of dynamic-range multiples. This block estimates that whole number. Each of the N channel terms arrives as a fixed-point fraction in [0, 1). The term is the channel's weighted residue already divided by its modulus. Only the top Q bits of each fraction are kept. The slices are added together with a constant offset. The integer part of that sum is the coefficient.

The coefficient also indexes a small parameter table of precomputed correction constants, and the selected entry is presented beside it. A controller pulses `start` once the channel terms are stable, which is after they have been latched upstream. One cycle later the block presents the coefficient, the table entry and a one-cycle `valid` pulse. The estimate is exact only while the reconstructed value stays inside the reduced effective range that the offset and slice width were chosen for. Keeping within that range is the system's responsibility.

Top module: `crt_coef_est`

## Requirements
- R1: Of each channel term (TERM_W bits, channel k at bits [k*TERM_W +: TERM_W]), only the top Q bits take part. Changing any lower bit leaves `coef` and `corr` unchanged.
- R2: The captured `coef` equals floor((sum over k of the top-Q slice of term k + OFFSET) / 2^Q). With the defaults (N=8, TERM_W=20, Q=8, OFFSET=4), the slice is term bits [19:12].
- R3: The internal sum of N slices plus OFFSET never exceeds Q+log2(N) bits. This requires OFFSET <= N-1, and the default is OFFSET=4.
- R4: `corr` equals table entry number `coef`, which is TABLE[coef*ENTRY_W +: ENTRY_W]. The default entry k holds k*16'h1111.
- R5: A high `start` sampled at a clock edge produces `valid`=1 in the following cycle only. `valid` is low in any cycle not preceded by `start`.
- R6: While `start` is low, `coef` and `corr` hold their last captured values whatever `terms` does.
- R7: After reset, `coef`, `corr` and `valid` are all zero.
- R8: The threshold is exact. With the default offset, a single nonzero slice of 252 together with zero slices gives coef 1, and a single slice of 251 gives coef 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Capture strobe; terms are sampled on this edge |
| terms | input | N*TERM_W | Packed channel fractions, channel k at [k*TERM_W +: TERM_W] |
| coef | output | log2(N) | Estimated dynamic-range multiple |
| corr | output | ENTRY_W | Correction constant selected by coef |
| valid | output | 1 | One-cycle pulse marking fresh outputs |

## Verification
Four things are checked on every cycle: that the slice sum never carries beyond its width, that `valid` pulses exactly one cycle after each `start`, that outputs hold between strobes, and that `corr` always matches the table entry for the held `coef`. Only the bench scenarios can show that the coefficient is numerically right. Those scenarios are the all-zero, all-one and mixed slice patterns, the exact integer threshold, and the lower bits that must not matter.

// File: rtl/crt_coef_est.sv
module crt_coef_est #(
  parameter int unsigned N       = 8,
  parameter int unsigned TERM_W  = 20,
  parameter int unsigned Q       = 8,
  parameter int unsigned OFFSET  = 4,
  parameter int unsigned ENTRY_W = 16,
  localparam int unsigned LOG_N  = $clog2(N),
  localparam int unsigned SUM_W  = Q + LOG_N,
  localparam int unsigned NENT   = 1 << LOG_N,
  parameter logic [NENT*ENTRY_W-1:0] TABLE = {
    16'h7777, 16'h6666, 16'h5555, 16'h4444,
    16'h3333, 16'h2222, 16'h1111, 16'h0000}
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [N*TERM_W-1:0]   terms,
  output logic [LOG_N-1:0]      coef,
  output logic [ENTRY_W-1:0]    corr,
  output logic                  valid
);

  logic [SUM_W:0]     sum_w;
  logic [LOG_N-1:0]   idx;

  always_comb begin
    sum_w = (SUM_W+1)'(OFFSET);
    for (int k = 0; k < N; k++)
      sum_w = sum_w + {{(SUM_W+1-Q){1'b0}}, terms[k*TERM_W + TERM_W - Q +: Q]};
  end

  assign idx = sum_w[SUM_W-1:Q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef  <= '0;
      corr  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        coef <= idx;
        corr <= TABLE[idx*ENTRY_W +: ENTRY_W];
      end
    end
  end

  initial begin
    a_offset_fits_r3: assert (OFFSET <= N - 1);
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !sum_w[SUM_W]);

  p_valid_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> valid);

  p_valid_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(coef) && $stable(corr));

  p_entry_matches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> corr == TABLE[coef*ENTRY_W +: ENTRY_W]);

endmodule

// File: tb/crt_coef_est_tb.sv
module crt_coef_est_tb;
  localparam int N = 8, TERM_W = 20, Q = 8, ENTRY_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [N*TERM_W-1:0] terms = '0;
  logic [2:0]        coef;
  logic [15:0]       corr;
  logic              valid;

  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  crt_coef_est u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .terms(terms),
    .coef(coef), .corr(corr), .valid(valid));

  // {slices k7..k0 (8 bits each), low-bit fill, expected coef}
  localparam int NV = 9;
  localparam logic [63+12+3:0] VEC [NV] = '{
    {64'h0000000000000000, 12'h000, 3'd0},
    {64'h0000000000000000, 12'hFFF, 3'd0},
    {64'h2020202020202020, 12'h5A5, 3'd1},
    {64'hFFFFFFFFFFFFFFFF, 12'hFFF, 3'd7},
    {64'h8080808080808080, 12'h000, 3'd4},
    {64'h00000000000000FB, 12'hFFF, 3'd0},
    {64'h00000000000000FC, 12'h000, 3'd1},
    {64'h8070605040302010, 12'h123, 3'd2},
    {64'h8070605040302010, 12'hEDC, 3'd2}
  };

  function automatic logic [N*TERM_W-1:0] build(input logic [63:0] sl, input logic [11:0] lo);
    logic [N*TERM_W-1:0] t;
    for (int k = 0; k < N; k++) t[k*TERM_W +: TERM_W] = {sl[k*8 +: 8], lo};
    return t;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic fire(input logic [N*TERM_W-1:0] t);
    @(negedge clk);
    terms = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R7 coef", 32'(coef), 0);
    check("R7 corr", 32'(corr), 0);
    check("R7 valid", 32'(valid), 0);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] e;
      e = VEC[v][2:0];
      fire(build(VEC[v][78:15], VEC[v][14:3]));
      check("R2/R1/R8 coef", 32'(coef), 32'(e));
      check("R4 corr", 32'(corr), 32'(e) * 32'h1111);
      check("R5 valid high", 32'(valid), 1);
      @(negedge clk);
      check("R5 valid one cycle", 32'(valid), 0);
    end

    // R3: largest slices stay in range
    fire(build(64'hFFFFFFFFFFFFFFFF, 12'h000));
    check("R3 max sum coef", 32'(coef), 7);

    // R6: terms change while start low; outputs hold
    @(negedge clk);
    terms = '0;
    repeat (3) @(negedge clk);
    check("R6 coef held", 32'(coef), 7);
    check("R6 corr held", 32'(corr), 32'h7777);
    check("R5 no valid without start", 32'(valid), 0);

    // R5: back-to-back strobes
    @(negedge clk);
    terms = build(64'h0000000000000080, 12'h000);
    start = 1'b1;
    @(negedge clk);
    check("R5 b2b first valid", 32'(valid), 1);
    check("R2 b2b first coef", 32'(coef), 0);
    terms = build(64'h4040404040404040, 12'h000);
    @(negedge clk);
    start = 1'b0;
    check("R5 b2b second valid", 32'(valid), 1);
    check("R2 b2b second coef", 32'(coef), 2);
    check("R4 b2b corr", 32'(corr), 32'h2222);

    // R7: reset clears captured values
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7 coef after reset", 32'(coef), 0);
    check("R7 corr after reset", 32'(corr), 0);
    rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule